// File: doc/BRIEF.md
# Binary Spin Metropolis Update Engine

This block applies one Metropolis trial flip to a single site of a three-dimensional binary spin lattice. Each site has six nearest neighbours. Every cycle it can accept a new site: the site spin bit, one spin bit per neighbour, one coupling bit per bond, and an unsigned random word. A bit value of 1 stands for +1 and a bit value of 0 stands for −1. The engine returns the spin bit to write back, two cycles later. Lattice storage, site ordering and random number generation are done outside the block.

The engine XORs each coupling bit with its neighbour spin bit and counts the ones. From that count and the site bit it finds the mismatch count Σ, the number of bonds whose term σi ⊕ γij ⊕ σj is 1. The energy change of the flip is then 4·Σ − 12, or in general 4·Σ − 2·NBR. When this change is zero or negative, the flip is always accepted. When it is positive, the engine reads a threshold from a small table that holds exp(−β·ΔE) already scaled to the random word width. The flip is accepted only when the random word is strictly below that threshold.

The table is filled through a one-word write port, between sweeps. A parameter picks one of two layouts. The direct layout has 2·(NBR+1) entries indexed by the site bit and the neighbour count. The mirrored layout has NBR+1 entries indexed by Σ.

Top module: `spin_metropolis_engine`

## Requirements
- R1: While reset is asserted, and after reset until the first input, `upd_valid` is 0.
- R2: Every cycle with `site_valid` high produces exactly one cycle with `upd_valid` high, two clock cycles later. A cycle with `site_valid` low produces `upd_valid` low two cycles later.
- R3: Bit 1 encodes spin or coupling +1. Σ is the number of bonds j for which `site_spin` ⊕ `bond_coupling[j]` ⊕ `nbr_spin[j]` is 1, and ranges from 0 to NBR.
- R4: When 2·Σ ≤ NBR (energy change ≤ 0), `upd_spin` is the inverse of `site_spin`, whatever the random word and the table contents.
- R5: When 2·Σ > NBR, `upd_spin` is the inverse of `site_spin` if `rand_word` < threshold (unsigned compare). Otherwise `upd_spin` equals `site_spin`. A random word equal to the threshold is a rejection.
- R6: With IDX_MODE = IDX_DIRECT, the threshold address is c when `site_spin` is 0 and NBR+1+c when `site_spin` is 1. Here c is the count of ones in `bond_coupling` ⊕ `nbr_spin`.
- R7: With IDX_MODE = IDX_MIRROR, the threshold address is Σ. A write to an address above NBR changes no entry.
- R8: Reset clears every table entry to 0. Until an entry is written, a site that reads it with positive energy change keeps its spin.
- R9: A table write is visible to every update whose input is presented after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| site_valid | input | 1 | Input site is present this cycle |
| site_spin | input | 1 | Current spin of the site (1 = +1) |
| nbr_spin | input | NBR | Neighbour spin bits |
| bond_coupling | input | NBR | Coupling bit of each bond (1 = +1) |
| rand_word | input | RND_W | Unsigned random word |
| thr_wr_en | input | 1 | Threshold table write strobe |
| thr_wr_addr | input | $clog2(2·(NBR+1)) | Threshold table write address |
| thr_wr_data | input | RND_W | Threshold value to store |
| upd_valid | output | 1 | Updated spin is present |
| upd_spin | output | 1 | Spin bit to write back |

## Verification
The bench builds two copies with the default six neighbours and 32-bit random words. One copy uses the direct layout and the other the mirrored layout. Both are fed the same stream. Six neighbours make the whole 13-bit input space small enough to sweep completely, twice. Each random word is placed just below, at and just above the threshold the site reads, and also at zero and at all-ones. This brings every mismatch count, the equality boundary and the mirror relation between the two table layouts within reach. Zeroed tables before loading, an all-zero entry, an all-ones entry, ignored writes above the mirrored depth, and idle gaps inside the stream cover the reset, table and valid-timing cases.

// File: rtl/spin_pkg.sv
package spin_pkg;

   // Layout of the acceptance threshold table
   typedef enum logic {
      IDX_DIRECT = 1'b0,   // 2*(NBR+1) entries indexed by {site, neighbour count}
      IDX_MIRROR = 1'b1    // NBR+1 entries indexed by mismatch count
   } idx_mode_e;

   // Number of entries the table needs for a given layout
   function automatic int table_depth(input idx_mode_e mode, input int nbr);
      return (mode == IDX_DIRECT) ? 2 * (nbr + 1) : nbr + 1;
   endfunction

endpackage

// File: rtl/spin_bond_counter.sv
module spin_bond_counter #(
   parameter int NBR = 6,
   parameter int CW  = $clog2(NBR + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NBR-1:0] nbr_spin,
   input  logic [NBR-1:0] bond_coupling,
   output logic [CW-1:0]  nbr_count
);

   logic [NBR-1:0] bond_bit;

   // One XOR per bond; the site spin is folded in later
   for (genvar g = 0; g < NBR; g++) begin : g_bond
      assign bond_bit[g] = nbr_spin[g] ^ bond_coupling[g];
   end

   always_comb begin
      nbr_count = '0;
      for (int j = 0; j < NBR; j++) begin
         nbr_count = nbr_count + CW'(bond_bit[j]);
      end
   end

   // R3: a count of NBR bits can never exceed NBR
   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      nbr_count <= CW'(NBR));

endmodule

// File: rtl/spin_threshold_table.sv
module spin_threshold_table
   import spin_pkg::*;
#(
   parameter int        NBR      = 6,
   parameter int        RND_W    = 32,
   parameter idx_mode_e IDX_MODE = IDX_DIRECT,
   parameter int        CW       = $clog2(NBR + 1),
   parameter int        AW       = $clog2(2 * (NBR + 1))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [RND_W-1:0] wr_data,
   input  logic             rd_site,
   input  logic [CW-1:0]    rd_nbr_count,
   input  logic [CW-1:0]    rd_mismatch,
   output logic [RND_W-1:0] rd_thr
);

   localparam int DEPTH = table_depth(IDX_MODE, NBR);

   logic [DEPTH-1:0][RND_W-1:0] mem;
   logic [AW-1:0]               rd_idx;

   // Index variant selected by the layout parameter
   if (IDX_MODE == IDX_DIRECT) begin : g_direct
      always_comb begin
         if (rd_site) rd_idx = AW'(NBR + 1) + AW'(rd_nbr_count);
         else         rd_idx = AW'(rd_nbr_count);
      end
   end else begin : g_mirror
      always_comb rd_idx = AW'(rd_mismatch);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && wr_addr == AW'(e)) mem[e] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_thr = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (rd_idx == AW'(e)) rd_thr = mem[e];
      end
   end

   // R7: writes outside the populated range leave every entry untouched
   assert_ignore_high_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr >= AW'(DEPTH)) |=> $stable(mem));

endmodule

// File: rtl/spin_accept_stage.sv
module spin_accept_stage #(
   parameter int NBR   = 6,
   parameter int RND_W = 32,
   parameter int CW    = $clog2(NBR + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_site,
   input  logic [CW-1:0]    in_mismatch,
   input  logic [RND_W-1:0] in_rand,
   input  logic [RND_W-1:0] in_thr,
   output logic             out_valid,
   output logic             out_spin
);

   logic [CW:0] twice_mis;
   logic        downhill;
   logic        below_thr;
   logic        accept;

   assign twice_mis = {in_mismatch, 1'b0};
   assign downhill  = twice_mis <= (CW + 1)'(NBR);
   assign below_thr = in_rand < in_thr;
   assign accept    = downhill | below_thr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_spin  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_spin  <= in_site ^ accept;
      end
   end

   // R4: non-positive energy change always flips
   assert_downhill_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (2 * int'(in_mismatch) <= NBR)) |=> (out_spin != $past(in_site)));

   // R5: positive energy change with random at or above threshold keeps the spin
   assert_reject_at_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (2 * int'(in_mismatch) > NBR) && (in_rand >= in_thr))
      |=> (out_spin == $past(in_site)));

endmodule

// File: rtl/spin_metropolis_engine.sv
module spin_metropolis_engine
   import spin_pkg::*;
#(
   parameter int        NBR      = 6,
   parameter int        RND_W    = 32,
   parameter idx_mode_e IDX_MODE = IDX_DIRECT,
   localparam int       CW       = $clog2(NBR + 1),
   localparam int       AW       = $clog2(2 * (NBR + 1))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             site_valid,
   input  logic             site_spin,
   input  logic [NBR-1:0]   nbr_spin,
   input  logic [NBR-1:0]   bond_coupling,
   input  logic [RND_W-1:0] rand_word,
   input  logic             thr_wr_en,
   input  logic [AW-1:0]    thr_wr_addr,
   input  logic [RND_W-1:0] thr_wr_data,
   output logic             upd_valid,
   output logic             upd_spin
);

   // Elaboration-time parameter checks
   if (NBR < 1 || NBR > 30) begin : g_bad_nbr
      $error("spin_metropolis_engine: NBR out of range");
   end
   if (RND_W < 2 || RND_W > 64) begin : g_bad_rnd
      $error("spin_metropolis_engine: RND_W out of range");
   end

   logic [CW-1:0]    nbr_count;
   logic             s1_valid;
   logic             s1_site;
   logic [CW-1:0]    s1_count;
   logic [RND_W-1:0] s1_rand;
   logic [CW-1:0]    s1_mismatch;
   logic [RND_W-1:0] s1_thr;

   spin_bond_counter #(.NBR(NBR), .CW(CW)) i_count (
      .clk           (clk),
      .rst_n         (rst_n),
      .nbr_spin      (nbr_spin),
      .bond_coupling (bond_coupling),
      .nbr_count     (nbr_count)
   );

   // Stage 1 register: count, site bit and random word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_site  <= 1'b0;
         s1_count <= '0;
         s1_rand  <= '0;
      end else begin
         s1_valid <= site_valid;
         s1_site  <= site_spin;
         s1_count <= nbr_count;
         s1_rand  <= rand_word;
      end
   end

   // Site spin 1 complements every bond term
   assign s1_mismatch = s1_site ? (CW'(NBR) - s1_count) : s1_count;

   spin_threshold_table #(
      .NBR(NBR), .RND_W(RND_W), .IDX_MODE(IDX_MODE), .CW(CW), .AW(AW)
   ) i_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (thr_wr_en),
      .wr_addr      (thr_wr_addr),
      .wr_data      (thr_wr_data),
      .rd_site      (s1_site),
      .rd_nbr_count (s1_count),
      .rd_mismatch  (s1_mismatch),
      .rd_thr       (s1_thr)
   );

   spin_accept_stage #(.NBR(NBR), .RND_W(RND_W), .CW(CW)) i_accept (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (s1_valid),
      .in_site     (s1_site),
      .in_mismatch (s1_mismatch),
      .in_rand     (s1_rand),
      .in_thr      (s1_thr),
      .out_valid   (upd_valid),
      .out_spin    (upd_spin)
   );

   // R2: one output two cycles after each input
   assert_latency_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      site_valid |-> ##2 upd_valid);
   assert_latency_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !site_valid |-> ##2 !upd_valid);

endmodule

// File: tb/test_spin_metropolis_engine.sv
module test_spin_metropolis_engine;
   import spin_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        site_valid = 1'b0;
   logic        site_spin = 1'b0;
   logic [5:0]  nbr_spin = '0;
   logic [5:0]  bond_coupling = '0;
   logic [31:0] rand_word = '0;
   logic        thr_wr_en = 1'b0;
   logic [3:0]  thr_wr_addr = '0;
   logic [31:0] thr_wr_data = '0;
   logic        vld_d, spin_d, vld_m, spin_m;

   logic [31:0] tbl [14];
   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   spin_metropolis_engine #(.NBR(6), .RND_W(32), .IDX_MODE(IDX_DIRECT)) i_spin_metropolis_engine (
      .clk(clk), .rst_n(rst_n), .site_valid(site_valid), .site_spin(site_spin),
      .nbr_spin(nbr_spin), .bond_coupling(bond_coupling), .rand_word(rand_word),
      .thr_wr_en(thr_wr_en), .thr_wr_addr(thr_wr_addr), .thr_wr_data(thr_wr_data),
      .upd_valid(vld_d), .upd_spin(spin_d));

   spin_metropolis_engine #(.NBR(6), .RND_W(32), .IDX_MODE(IDX_MIRROR)) i_spin_metropolis_engine_mir (
      .clk(clk), .rst_n(rst_n), .site_valid(site_valid), .site_spin(site_spin),
      .nbr_spin(nbr_spin), .bond_coupling(bond_coupling), .rand_word(rand_word),
      .thr_wr_en(thr_wr_en), .thr_wr_addr(thr_wr_addr), .thr_wr_data(thr_wr_data),
      .upd_valid(vld_m), .upd_spin(spin_m));

   function automatic int mis_count(input logic s, input logic [5:0] n, input logic [5:0] c);
      int m = 0;
      for (int j = 0; j < 6; j++) m += int'(s ^ n[j] ^ c[j]);
      return m;
   endfunction

   function automatic int tbl_index(input int mode, input logic s, input logic [5:0] n, input logic [5:0] c);
      int p = 0;
      for (int j = 0; j < 6; j++) p += int'(n[j] ^ c[j]);
      if (mode == 1) return mis_count(s, n, c);
      return s ? 7 + p : p;
   endfunction

   function automatic logic exp_spin(input int mode, input logic s, input logic [5:0] n,
                                     input logic [5:0] c, input logic [31:0] r);
      if (2 * mis_count(s, n, c) <= 6) return ~s;
      return (r < tbl[tbl_index(mode, s, n, c)]) ? ~s : s;
   endfunction

   // Reference pipeline of expected values (two-cycle latency)
   logic e1v, e1d, e1m, e2v, e2d, e2m;
   int   e1tag, e2tag;
   always @(posedge clk) begin
      if (!rst_n) begin
         e1v <= 1'b0; e2v <= 1'b0; e1d <= 1'b0; e1m <= 1'b0; e2d <= 1'b0; e2m <= 1'b0;
         e1tag <= 0; e2tag <= 0;
      end else begin
         e1v   <= site_valid;
         e1d   <= exp_spin(0, site_spin, nbr_spin, bond_coupling, rand_word);
         e1m   <= exp_spin(1, site_spin, nbr_spin, bond_coupling, rand_word);
         e1tag <= (2 * mis_count(site_spin, nbr_spin, bond_coupling) <= 6) ? 4 : 5;
         e2v <= e1v; e2d <= e1d; e2m <= e1m; e2tag <= e1tag;
      end
   end

   bit tables_loaded = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         checks += 2;
         if (vld_d !== e2v) begin
            fails++;
            $display("FAIL R2 direct valid: actual %b expected %b", vld_d, e2v);
         end
         if (vld_m !== e2v) begin
            fails++;
            $display("FAIL R2 mirror valid: actual %b expected %b", vld_m, e2v);
         end
         if (e2v) begin
            checks += 2;
            if (spin_d !== e2d) begin
               fails++;
               if (!tables_loaded && e2tag == 5)
                  $display("FAIL R8 direct spin: actual %b expected %b", spin_d, e2d);
               else if (e2tag == 4)
                  $display("FAIL R4 R3 direct spin: actual %b expected %b", spin_d, e2d);
               else
                  $display("FAIL R5 R6 R9 direct spin: actual %b expected %b", spin_d, e2d);
            end
            if (spin_m !== e2m) begin
               fails++;
               if (!tables_loaded && e2tag == 5)
                  $display("FAIL R8 mirror spin: actual %b expected %b", spin_m, e2m);
               else if (e2tag == 4)
                  $display("FAIL R4 R3 mirror spin: actual %b expected %b", spin_m, e2m);
               else
                  $display("FAIL R5 R7 R9 mirror spin: actual %b expected %b", spin_m, e2m);
            end
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int a = 0; a < 14; a++) tbl[a] = '0;
      // R1: outputs idle during reset
      repeat (4) @(negedge clk);
      checks += 2;
      if (vld_d !== 1'b0 || vld_m !== 1'b0) begin
         fails++;
         $display("FAIL R1 valid in reset: actual %b%b expected 00", vld_d, vld_m);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);   // checker covers R1 after release

      // R8: tables zero after reset, random 0 never passes a threshold of 0
      for (int k = 0; k < 8192; k += 19) begin
         @(negedge clk);
         site_valid = 1'b1;
         {site_spin, nbr_spin, bond_coupling} = 13'(k);
         rand_word = '0;
      end
      @(negedge clk) site_valid = 1'b0;
      repeat (3) @(negedge clk);

      // R9 R7: load thresholds; addresses 7..13 are ignored by the mirrored copy
      for (int a = 0; a < 14; a++) begin
         @(negedge clk);
         thr_wr_en   = 1'b1;
         thr_wr_addr = 4'(a);
         thr_wr_data = 32'h1357_9BDF * 32'(a + 3);
         if (a == 4)  thr_wr_data = 32'h0000_0000;
         if (a == 6)  thr_wr_data = 32'h8000_0000;
         if (a == 13) thr_wr_data = 32'hFFFF_FFFF;
         tbl[a] = thr_wr_data;
      end
      @(negedge clk) thr_wr_en = 1'b0;
      tables_loaded = 1'b1;

      // R3 R4 R5 R6 R7: exhaustive sweep, random word near each copy's threshold
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 8192; k++) begin
            logic [12:0] pat;
            logic [31:0] thr;
            pat = 13'(k);
            thr = tbl[tbl_index(pass, pat[12], pat[11:6], pat[5:0])];
            if (k % 11 == 10) begin
               @(negedge clk);
               site_valid = 1'b0;   // bubble
            end
            @(negedge clk);
            site_valid = 1'b1;
            {site_spin, nbr_spin, bond_coupling} = pat;
            case (k % 5)
               0: rand_word = thr - 32'd1;
               1: rand_word = thr;
               2: rand_word = thr + 32'd1;
               3: rand_word = '0;
               default: rand_word = '1;
            endcase
         end
      end
      @(negedge clk) site_valid = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule